// File: doc/BRIEF.md
# Burst Read Word Capture Controller

This controller sits next to a serial-bus master during burst reads and moves each received word into an external memory. Software or a sequencer arms it with a start pulse and a word count. The block copies the count into a register, raises busy, and then watches the master's per-word valid strobe.

The strobe can stay high for several clock cycles. The block acts only on its rising edge, so each word is written exactly once. Each write is a single-cycle write-enable pulse, with data and address presented in the same cycle. Addresses start at zero and step by one for each word.

When the latched number of words has been written, the block passes through a one-cycle done state. That state drops busy, zeroes the data and address outputs, and returns the block to idle. The memory itself is outside the block.

Top module: `burst_word_capture`

## Requirements
- R1: Synchronous active-high reset. In the first cycle after a reset edge, busy, memWe, memData and memAddr are all 0.
- R2: When start is high in a cycle while the block is idle, busy is high from the next cycle on.
- R3: The word count is copied when start is accepted. Changing burstCount later does not change how many writes that burst makes.
- R4: A write is triggered only when dataValid is 1 in a cycle after a cycle in which it was 0, and only while a burst is capturing. A strobe held high for many cycles gives one write. Strobe activity while idle gives no write.
- R5: memWe is high for exactly one cycle. That cycle is the one after the cycle in which the edge was seen, and memData then equals the rdData value sampled in the edge cycle. Between writes, memData and memAddr keep their last values.
- R6: The first write of a burst goes to address 0. Each later write goes to the previous address plus one, wrapping modulo 2^ADDR_W.
- R7: After the last write of a burst, busy stays high for the cycle in which memWe is high. In the following cycle, busy, memData and memAddr are 0.
- R8: A start with burstCount equal to 0 makes no write and keeps busy high for exactly one cycle.
- R9: start is ignored while busy. A burst of N words still makes N writes, and its addresses are not restarted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Arms a capture burst when idle |
| burstCount | input | COUNT_W | Number of words in the burst |
| dataValid | input | 1 | Per-word valid strobe from the serial master |
| rdData | input | DATA_W | Word received by the serial master |
| busy | output | 1 | High from arming until the done state is left |
| memWe | output | 1 | One-cycle memory write enable |
| memData | output | DATA_W | Word written to memory |
| memAddr | output | ADDR_W | Memory address of the write |

## Verification
The bench builds the block with DATA_W = 16, COUNT_W = 16 and a narrow ADDR_W = 3. The narrow address width lets a ten-word burst carry the address across its wrap point back to 0.

The 16-bit count keeps the terminal comparison at full width, including the zero-count case. The 16-bit data width lets every captured word carry a distinct tag, so a missed edge or a duplicated write shows up in the data.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  typedef enum logic [7:0] {
    ST_IDLE    = 8'h00,
    ST_CAPTURE = 8'h01,
    ST_DONE    = 8'h02
  } capState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLen;    // accept a new burst
    logic writeWord;  // write the current word
    logic clearOut;   // zero the memory-side outputs
  } capStrobe_t;
endpackage

// File: rtl/bwc_control.sv
module bwc_control
  import bwc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       validEdge,
  input  logic       lastWord,
  input  logic       lenZero,
  output capStrobe_t strobe,
  output logic       busy
);
  capState_t state;

  always_comb begin
    strobe.loadLen   = (state == ST_IDLE) && start;
    strobe.writeWord = (state == ST_CAPTURE) && validEdge;
    strobe.clearOut  = (state == ST_DONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      busy  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          busy  <= 1'b1;
          state <= lenZero ? ST_DONE : ST_CAPTURE;
        end
        ST_CAPTURE: if (validEdge && lastWord) state <= ST_DONE;
        ST_DONE: begin
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start) |=> busy);

  // R7
  done_return_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |=> (state == ST_IDLE && !busy));
endmodule

// File: rtl/bwc_datapath.sv
module bwc_datapath
  import bwc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 16,
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  capStrobe_t         strobe,
  input  logic [COUNT_W-1:0] burstCount,
  input  logic               dataValid,
  input  logic [DATA_W-1:0]  rdData,
  output logic               validEdge,
  output logic               lastWord,
  output logic               lenZero,
  output logic               memWe,
  output logic [DATA_W-1:0]  memData,
  output logic [ADDR_W-1:0]  memAddr
);
  localparam int CW1 = COUNT_W + 1;

  logic               prevValid;
  logic [COUNT_W-1:0] lenReg;
  logic [COUNT_W-1:0] wordCnt;
  logic [ADDR_W-1:0]  nextAddr;
  logic [CW1-1:0]     cntPlusOne;

  assign validEdge  = dataValid && !prevValid;
  assign cntPlusOne = {1'b0, wordCnt} + CW1'(1);
  assign lastWord   = (cntPlusOne == {1'b0, lenReg});
  assign lenZero    = (burstCount == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      prevValid <= 1'b0;
      lenReg    <= '0;
      wordCnt   <= '0;
      nextAddr  <= '0;
      memWe     <= 1'b0;
      memData   <= '0;
      memAddr   <= '0;
    end else begin
      prevValid <= dataValid;
      memWe     <= strobe.writeWord;
      if (strobe.loadLen) begin
        lenReg   <= burstCount;
        wordCnt  <= '0;
        nextAddr <= '0;
      end
      if (strobe.writeWord) begin
        memData  <= rdData;
        memAddr  <= nextAddr;
        nextAddr <= nextAddr + ADDR_W'(1);
        wordCnt  <= wordCnt + COUNT_W'(1);
      end
      if (strobe.clearOut) begin
        memData <= '0;
        memAddr <= '0;
        wordCnt <= '0;
      end
    end
  end

  // R5
  data_capture_chk: assert property (@(posedge clk) disable iff (rst)
    memWe |-> (memData == $past(rdData)));

  // R3
  no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    wordCnt <= lenReg);
endmodule

// File: rtl/burst_word_capture.sv
module burst_word_capture
  import bwc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 16,
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [COUNT_W-1:0] burstCount,
  input  logic               dataValid,
  input  logic [DATA_W-1:0]  rdData,
  output logic               busy,
  output logic               memWe,
  output logic [DATA_W-1:0]  memData,
  output logic [ADDR_W-1:0]  memAddr
);
  capStrobe_t strobe;
  logic validEdge, lastWord, lenZero;

  bwc_control ctrl_i (
    .clk(clk), .rst(rst), .start(start), .validEdge(validEdge),
    .lastWord(lastWord), .lenZero(lenZero), .strobe(strobe), .busy(busy)
  );

  bwc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .burstCount(burstCount),
    .dataValid(dataValid), .rdData(rdData), .validEdge(validEdge),
    .lastWord(lastWord), .lenZero(lenZero), .memWe(memWe),
    .memData(memData), .memAddr(memAddr)
  );

  // R7
  we_busy_chk: assert property (@(posedge clk) disable iff (rst)
    memWe |-> busy);

  // R5
  we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    memWe |=> !memWe);
endmodule

// File: tb/burst_word_capture_tb_top.sv
module burst_word_capture_tb_top;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;
  localparam int COUNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [COUNT_W-1:0] burstCount = '0;
  logic dataValid = 1'b0;
  logic [DATA_W-1:0] rdData = '0;
  logic busy, memWe;
  logic [DATA_W-1:0] memData;
  logic [ADDR_W-1:0] memAddr;

  always #10 clk = ~clk;

  burst_word_capture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .burstCount(burstCount),
    .dataValid(dataValid), .rdData(rdData), .busy(busy), .memWe(memWe),
    .memData(memData), .memAddr(memAddr)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference, one step per clock
  int mMode = 0, mLen = 0, mCnt = 0, mNext = 0;
  bit mPrev = 0;
  int eBusy = 0, eWe = 0, eData = 0, eAddr = 0;
  always @(posedge clk) begin
    bit edgeNow;
    if (rst) begin
      mMode = 0; mLen = 0; mCnt = 0; mNext = 0; mPrev = 0;
      eBusy = 0; eWe = 0; eData = 0; eAddr = 0;
    end else begin
      edgeNow = dataValid && !mPrev;
      mPrev = dataValid;
      eWe = 0;
      case (mMode)
        0: if (start) begin
          eBusy = 1; mLen = int'(burstCount); mCnt = 0; mNext = 0;
          mMode = (burstCount == 0) ? 2 : 1;
        end
        1: if (edgeNow) begin
          eWe = 1; eData = int'(rdData); eAddr = mNext % (1 << ADDR_W);
          mNext++; mCnt++;
          if (mCnt == mLen) mMode = 2;
        end
        default: begin
          eBusy = 0; eData = 0; eAddr = 0; mMode = 0;
        end
      endcase
    end
  end

  // per-cycle comparison and bookkeeping, away from the active edge
  int cyc = 0, wrCount = 0, busyCycles = 0, lastWeCyc = 0, fallCyc = 0;
  bit prevBusy = 0;
  int addrQ[$];
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(int'(busy) == eBusy, "R2/R7 busy", int'(busy), eBusy);
      chk(int'(memWe) == eWe, "R4/R5 memWe", int'(memWe), eWe);
      chk(int'(memData) == eData, "R5 memData", int'(memData), eData);
      chk(int'(memAddr) == eAddr, "R6 memAddr", int'(memAddr), eAddr);
      if (memWe) begin
        wrCount++; lastWeCyc = cyc; addrQ.push_back(int'(memAddr));
      end
      if (busy) busyCycles++;
      if (prevBusy && !busy) fallCyc = cyc;
      prevBusy = busy;
    end
  end

  task automatic arm(input int n);
    @(negedge clk); start = 1'b1; burstCount = COUNT_W'(n);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse(input int width, input int gap, input int val);
    @(negedge clk); dataValid = 1'b1; rdData = DATA_W'(val);
    repeat (width - 1) @(negedge clk);
    @(negedge clk); dataValid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (busy);
    @(negedge clk);
  endtask

  task automatic clearStats();
    wrCount = 0; busyCycles = 0; addrQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs after reset
    chk(busy == 0 && memWe == 0, "R1 ctl", int'(busy) + int'(memWe), 0);
    chk(memData == 0 && memAddr == 0, "R1 data", int'(memData) + int'(memAddr), 0);
    rst = 1'b0;
    @(negedge clk);

    // R4: strobe while idle writes nothing
    clearStats();
    pulse(1, 1, 16'h1111);
    pulse(3, 2, 16'h2222);
    chk(wrCount == 0, "R4 idle", wrCount, 0);

    // R3, R4: burst of 3, count input changed after arming, wide strobe
    clearStats();
    arm(3);
    burstCount = 16'd9;
    pulse(6, 1, 16'hA001);
    chk(wrCount == 1, "R4 wide strobe", wrCount, 1);
    pulse(1, 1, 16'hA002);
    pulse(2, 3, 16'hA003);
    waitIdle();
    chk(wrCount == 3, "R3 count latched", wrCount, 3);
    chk(fallCyc - lastWeCyc == 1, "R7 busy fall", fallCyc - lastWeCyc, 1);
    chk(addrQ.size() == 3 && addrQ[0] == 0 && addrQ[2] == 2, "R6 sequence",
        addrQ.size() > 2 ? addrQ[2] : -1, 2);
    chk(memData == 0 && memAddr == 0, "R7 cleared", int'(memData), 0);

    // R8: zero count
    clearStats();
    arm(0);
    repeat (3) @(negedge clk);
    chk(busyCycles == 1, "R8 busy cycles", busyCycles, 1);
    chk(wrCount == 0, "R8 writes", wrCount, 0);

    // R9: start while busy ignored
    clearStats();
    arm(4);
    pulse(1, 1, 16'hB001);
    pulse(1, 1, 16'hB002);
    arm(2);
    pulse(1, 1, 16'hB003);
    pulse(1, 1, 16'hB004);
    waitIdle();
    chk(wrCount == 4, "R9 writes", wrCount, 4);
    chk(addrQ.size() == 4 && addrQ[3] == 3, "R9 address", addrQ.size() > 3 ? addrQ[3] : -1, 3);

    // R6: address wrap, strobe already high at arming
    clearStats();
    dataValid = 1'b1;
    arm(10);
    @(negedge clk); dataValid = 1'b0;
    @(negedge clk);
    chk(wrCount == 0, "R4 level at arm", wrCount, 0);
    for (int i = 0; i < 10; i++) pulse(1, 1, 16'hC000 + i);
    waitIdle();
    chk(wrCount == 10, "R6 writes", wrCount, 10);
    chk(addrQ.size() == 10 && addrQ[8] == 0 && addrQ[9] == 1, "R6 wrap",
        addrQ.size() > 9 ? addrQ[8] : -1, 0);

    // R1: reset during a burst
    arm(5);
    pulse(1, 1, 16'hD001);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk(busy == 0 && memWe == 0 && memData == 0 && memAddr == 0, "R1 mid-burst",
        int'(busy) + int'(memData), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule